// File: doc/BRIEF.md
# SPI Flash Status Protection Model

This block is a synthesizable model of the control side of a serial NOR flash device. It covers the opcode decoder and the status register of such a device. It is used on a verification platform to check lock-down sequences. A host drives SPI mode-0 frames that chip select brackets. The model answers identity and status reads. It tracks a write-enable latch, three block-protect bits and a register lock bit. After an accepted status write it runs a self-timed busy period. A hardware write-protect pin (active low) takes part in the lock rules. There is no memory array, and there are no program or erase commands.

The SPI inputs are sampled in the system clock domain, so SCK must run at least eight times slower than `clk`. MOSI is captured on the rising SCK edge. MISO changes after the falling SCK edge, starting with the edge that follows the eighth bit. A frame takes effect when chip select rises. Frames that are too short have no effect at all.

Top module: `spi_stat_model`

## Requirements
- R1: After reset, the status byte reads 0x10 while `wp_n` is high: all protection bits are clear, write-enable (bit 1) is clear and busy (bit 0) is clear.
- R2: Opcode 0x9F returns the bytes 0x1F, 0x45 and 0x01 in that order, MSB first, on the bits that follow the opcode. MISO stays low while chip select is high.
- R3: Opcode 0x05 returns the status byte repeatedly. Its layout is bit 7 lock, bit 5 and bits 3:2 block protect, bit 4 the level of `wp_n` (1 = pin inactive), bit 6 zero, bit 1 write-enable, bit 0 busy. The byte is snapshotted as each byte starts.
- R4: Opcode 0x06 sets the write-enable bit and arms a status write. Opcode 0x50 only arms a status write.
- R5: Opcode 0x01 with a data byte is accepted only if the frame right before it was 0x06 or 0x50. Otherwise the status and busy bit stay unchanged.
- R6: An accepted status write sets busy for BUSY_CYCLES clocks while the old value stays visible. When busy ends, the new value takes effect and write-enable clears.
- R7: With the lock bit clear, a status write changes only bits 7, 5, 3 and 2 (mask 0xAC). Writing 0xBC sets full protection together with the lock.
- R8: With the lock set and `wp_n` high, a status write changes only bit 7. The block-protect bits keep their values.
- R9: With the lock set and `wp_n` low, a status write runs its busy period but changes no protection bit.
- R10: While busy, only 0x05 is honoured. 0x06 has no effect, and 0x9F returns zero bytes.
- R11: A frame ends with chip select rising. A frame with fewer than 8 bits, or a 0x01 frame with fewer than 16 bits, is discarded with no effect, and any armed enable survives it.
- R12: Any other complete frame between the enable and 0x01 cancels the enable, including a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, mode 0, slower than clk/8 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the model |
| spi_miso | output | 1 | Serial data out of the model |
| wp_n | input | 1 | Hardware write-protect pin, active low |

## Verification
The hardest state to reach is the pinned lock. The lock bit must be set through a full enable-write-busy cycle before the pin goes low. A later write then has to finish its busy period without changing anything. The stimulus first builds full protection with 0xBC. It then shows that clearing the lock with the pin high leaves the protect bits alone, relocks, pulls the pin low and writes again. The busy window is then used to issue a write-enable and an identity read, which must both be ignored.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam logic [7:0] OP_RDID = 8'h9F;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_WRSR = 8'h01;

    // bits a status write may touch: lock (7) and protect (5, 3, 2)
    localparam logic [7:0] PROT_MASK = 8'hAC;
    localparam int unsigned CNT_W = 8;

    typedef struct packed {
        logic [7:0]       op;
        logic [7:0]       arg;
        logic [CNT_W-1:0] nbits;
    } frame_t;

    function automatic logic [7:0] id_byte(input logic [CNT_W-1:0] idx);
        case (idx)
            8'd0:    return 8'h1F;
            8'd1:    return 8'h45;
            8'd2:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // protection bits after a completed status write
    function automatic logic [7:0] prot_next(input logic [7:0] cur,
                                             input logic [7:0] wr,
                                             input logic pin_active);
        if (cur[7]) begin
            if (pin_active) return cur;
            return {wr[7], cur[6:0]};
        end
        return wr & PROT_MASK;
    endfunction

endpackage

// File: rtl/sfp_frame_rx.sv
module sfp_frame_rx
    import sfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck,
    input  logic   cs_n,
    input  logic   mosi,
    output logic   sck_fall,
    output logic   done,
    output frame_t fr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             sck_q, cs_q;
    logic [7:0]       sh;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op_q, arg_q;
    logic [7:0]       sh_nx;

    assign sh_nx    = {sh[6:0], mosi};
    assign sck_fall = !sck && sck_q && !cs_n;
    assign done     = cs_n && !cs_q;
    assign fr       = '{op: op_q, arg: arg_q, nbits: cnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            sh    <= '0;
            cnt   <= '0;
            op_q  <= '0;
            arg_q <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (!cs_n && cs_q) begin
                cnt  <= '0;
                op_q <= '0;
            end else if (!cs_n && sck && !sck_q) begin
                sh <= sh_nx;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(7))  op_q  <= sh_nx;
                if (cnt == CNT_W'(15)) arg_q <= sh_nx;
            end
        end
    end
endmodule

// File: rtl/sfp_stat_reg.sv
module sfp_stat_reg
    import sfp_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  frame_t     fr,
    input  logic       wp_n,
    output logic [7:0] status,
    output logic       busy
);
    localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

    logic [7:0]    prot, pend;
    logic          wel, armed;
    logic [BW-1:0] left;

    assign busy   = (left != '0);
    assign status = (prot & PROT_MASK) | {3'b000, wp_n, 2'b00, wel, busy};

    always_ff @(posedge clk) begin
        if (rst) begin
            prot  <= '0;
            pend  <= '0;
            wel   <= 1'b0;
            armed <= 1'b0;
            left  <= '0;
        end else if (busy) begin
            left <= left - 1'b1;
            if (left == BW'(1)) begin
                prot <= prot_next(prot, pend, !wp_n);
                wel  <= 1'b0;
            end
        end else if (done && fr.nbits >= CNT_W'(8)) begin
            case (fr.op)
                OP_WREN: begin
                    wel   <= 1'b1;
                    armed <= 1'b1;
                end
                OP_EWSR: armed <= 1'b1;
                OP_WRSR: begin
                    if (fr.nbits >= CNT_W'(16)) begin
                        armed <= 1'b0;
                        if (armed) begin
                            pend <= fr.arg;
                            left <= BW'(BUSY_CYCLES);
                        end
                    end
                end
                default: armed <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sfp_resp_tx.sv
module sfp_resp_tx
    import sfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck_fall,
    input  frame_t     fr,
    input  logic [7:0] status,
    input  logic       busy,
    output logic       miso
);
    logic [7:0]       tx;
    logic [7:0]       resp;
    logic [CNT_W-1:0] idx;

    assign idx = (fr.nbits - CNT_W'(8)) >> 3;

    always_comb begin
        resp = 8'h00;
        if (fr.op == OP_RDSR)            resp = status;
        else if (fr.op == OP_RDID && !busy) resp = id_byte(idx);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            tx   <= '0;
            miso <= 1'b0;
        end else if (sck_fall && fr.nbits >= CNT_W'(8)) begin
            if (fr.nbits[2:0] == 3'd0) begin
                miso <= resp[7];
                tx   <= {resp[6:0], 1'b0};
            end else begin
                miso <= tx[7];
                tx   <= {tx[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_stat_model.sv
module spi_stat_model
    import sfp_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wp_n
);
    frame_t     fr;
    logic       sck_fall, done, busy;
    logic [7:0] stat_q;

    sfp_frame_rx u_rx (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_fall(sck_fall), .done(done), .fr(fr)
    );

    sfp_stat_reg #(.BUSY_CYCLES(BUSY_CYCLES)) u_st (
        .clk(clk), .rst(rst), .done(done), .fr(fr), .wp_n(wp_n),
        .status(stat_q), .busy(busy)
    );

    sfp_resp_tx u_tx (
        .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck_fall(sck_fall), .fr(fr),
        .status(stat_q), .busy(busy), .miso(spi_miso)
    );
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       miso,
    input logic       wp_n,
    input logic [7:0] status
);
    logic       lock, wel, wip;
    logic [2:0] bp;
    assign lock = status[7];
    assign bp   = {status[5], status[3:2]};
    assign wel  = status[1];
    assign wip  = status[0];

    p_miso_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !miso);
    p_busy_from_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> cs_n);
    p_busy_end_clears_wel_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel);
    p_locked_bp_stable_r8: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(bp));
    p_pinned_lock_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (lock && !wp_n) |=> lock);
    p_no_wel_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (wip && !wel) |=> !wel);
endmodule

bind spi_stat_model spi_stat_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .miso(spi_miso), .wp_n(wp_n),
    .status(stat_q)
);

// File: tb/sim_spi_stat_model.sv
module sim_spi_stat_model;
    localparam int BUSY = 600;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    int checks = 0, fails = 0;

    // behavioural reference state
    logic [7:0] m_prot = 8'h00, m_pend = 8'h00;
    bit m_wel = 0, m_armed = 0;
    int m_left = 0;

    always #10 clk = ~clk;

    spi_stat_model #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .wp_n(wp_n)
    );

    always @(posedge clk) begin
        if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_prot[7]) begin
                    if (wp_n) m_prot[7] = m_pend[7];
                end else m_prot = m_pend & 8'hAC;
                m_wel = 0;
            end
        end
    end

    function automatic logic [7:0] m_status();
        return m_prot | {3'b000, wp_n, 2'b00, m_wel, (m_left > 0)};
    endfunction

    function automatic logic [7:0] m_id(int k);
        if (m_left > 0) return 8'h00;
        case (k) 0: return 8'h1F; 1: return 8'h45; 2: return 8'h01; default: return 8'h00; endcase
    endfunction

    function automatic void m_commit(logic [7:0] op, logic [7:0] arg, int nbits);
        if (m_left > 0 || nbits < 8) return;
        case (op)
            8'h06: begin m_wel = 1; m_armed = 1; end
            8'h50: m_armed = 1;
            8'h01: if (nbits >= 16) begin
                if (m_armed) begin m_pend = arg; m_left = BUSY; end
                m_armed = 0;
            end
            default: m_armed = 0;
        endcase
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] op, input logic [7:0] arg, input int nbits,
                         output logic [23:0] rx, output logic [23:0] ex);
        rx = '0; ex = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? op[7-i] : (i < 16) ? arg[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i >= 8 && i < 32) rx[31-i] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
            if ((i + 1) >= 8 && (i + 1) % 8 == 0 && (i + 1) < 32) begin
                int k = (i + 1 - 8) / 8;
                ex[23-8*k -: 8] = (op == 8'h05) ? m_status() : (op == 8'h9F) ? m_id(k) : 8'h00;
            end
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        @(posedge clk); #1;
        m_commit(op, arg, nbits);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] arg, input int nbits);
        logic [23:0] r, e;
        frame(op, arg, nbits, r, e);
    endtask

    task automatic rdsr(string req, logic [7:0] want);
        logic [23:0] r, e;
        frame(8'h05, 8'h00, 16, r, e);
        chk({req, " model"}, {16'h0, r[23:16]}, {16'h0, e[23:16]});
        chk({req, " spec"},  {16'h0, r[23:16]}, {16'h0, want});
    endtask

    task automatic settle();
        repeat (BUSY + 50) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] r, e;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        checks++;
        if (miso !== 1'b0) begin fails++; $display("FAIL R2 idle miso actual=%b expected=0", miso); end

        rdsr("R1 reset", 8'h10);
        frame(8'h9F, 8'h00, 32, r, e);
        chk("R2 id", r, 24'h1F4501);
        chk("R2 id model", r, e);

        cmd(8'h01, 8'h0C, 16);                   // no enable before it
        rdsr("R5 unarmed write", 8'h10);

        cmd(8'h06, 8'h00, 8);
        rdsr("R4 wel set", 8'h12);               // this read also cancels the enable
        cmd(8'h01, 8'h0C, 16);
        rdsr("R12 cancelled", 8'h12);

        cmd(8'h06, 8'h00, 8);
        cmd(8'h01, 8'h0C, 12);                   // too short: discarded
        cmd(8'h01, 8'h0C, 16);
        rdsr("R6 busy old value", 8'h13);
        settle();
        rdsr("R6 R7 applied", 8'h1C);

        cmd(8'h06, 8'h00, 7);                    // short write-enable
        rdsr("R11 short frame", 8'h1C);

        cmd(8'h50, 8'h00, 8);
        rdsr("R4 ewsr no wel", 8'h1C);
        cmd(8'h50, 8'h00, 8);
        cmd(8'h01, 8'h53, 16);
        settle();
        rdsr("R7 mask", 8'h10);

        cmd(8'h06, 8'h00, 8);
        cmd(8'h01, 8'hBC, 16);
        settle();
        rdsr("R7 global", 8'hBC);

        cmd(8'h50, 8'h00, 8);
        cmd(8'h01, 8'h80, 16);
        settle();
        rdsr("R8 bp frozen", 8'hBC);
        cmd(8'h50, 8'h00, 8);
        cmd(8'h01, 8'h00, 16);
        settle();
        rdsr("R8 unlock only", 8'h3C);

        cmd(8'h50, 8'h00, 8);
        cmd(8'h01, 8'hBC, 16);
        settle();
        wp_n = 1'b0;
        rdsr("R3 pin bit", 8'hAC);
        cmd(8'h50, 8'h00, 8);
        cmd(8'h01, 8'h00, 16);
        rdsr("R9 busy runs", 8'hAD);
        cmd(8'h06, 8'h00, 8);                    // ignored while busy
        frame(8'h9F, 8'h00, 16, r, e);
        chk("R10 id while busy", {16'h0, r[23:16]}, 24'h0);
        settle();
        rdsr("R9 R10 still locked", 8'hAC);

        wp_n = 1'b1;
        rdsr("R3 pin released", 8'hBC);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule